// File: doc/BRIEF.md
# Vector Memory Address Generator

This block walks through the elements of one vector memory operation and emits one byte address per clock for each element, together with the element number, a write-enable flag taken from a per-element mask, and the memory bank that the access lands in. Three addressing patterns are supported: consecutive elements packed back to back, elements separated by a signed scalar stride, and indexed access where a base address is added to an offset streamed in for each element.

An operation is launched with a one-cycle `start` pulse that captures the base, the stride, the element size code, the mask and the active length. Elements leave strictly in order. The block keeps a short history of the banks it has recently used. If an enabled element would reach a bank that is still inside its busy window, the sequencer holds that element and raises `conflict` until the bank is free again. A one-cycle `done` pulse follows the last element.

Top module: `vec_addr_gen`

## Requirements
- R1: Without bank stalls or missing offsets, element i of an operation started at edge E is emitted at edge E+1+i, so one element appears per cycle.
- R2: Mode 0 (packed) produces base + i * 2^esize for element i, where esize is 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8 bytes per element.
- R3: Mode 1 (strided) produces base + i * stride, with stride a two's-complement byte distance and arithmetic done modulo 2^AW.
- R4: Mode 2 (indexed) produces base + idx_off for each element. An offset is taken on a cycle where `idx_valid` and `idx_ready` are both high. Each element uses exactly one offset, in element order, and nothing is emitted while `idx_valid` is low.
- R5: An operation emits exactly min(vlen, MAXVL) elements, numbered 0 upward in `out_elem`.
- R6: `out_en` equals bit i of the captured `mask` for element i. A masked element still takes its cycle in sequence, but it never stalls and never makes its bank busy.
- R7: `out_bank` equals (address >> esize) mod NBANK.
- R8: An enabled element issued at edge t makes its bank busy, so no enabled element to the same bank is issued before edge t+BUSY+1. `conflict` is high for exactly those cycles in which an element is held for this reason.
- R9: `done` is high for a single cycle, one cycle after the last element. An operation with length 0 emits no element and gives `done` one cycle after `start` is taken.
- R10: A `start` pulse while `busy` is high is ignored and does not change the operation in flight.
- R11: After reset `out_valid`, `conflict`, `done`, `busy` and `idx_ready` are low.
- R12: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation when idle |
| mode | input | 2 | 0 packed, 1 strided, 2 indexed, 3 packed |
| base | input | AW | Base byte address |
| stride | input | AW | Signed byte stride for mode 1 |
| vlen | input | CW | Requested element count, clamped to MAXVL |
| esize | input | 2 | log2 of element size in bytes |
| mask | input | MAXVL | Per-element enable, bit i for element i |
| idx_valid | input | 1 | An index offset is present |
| idx_off | input | AW | Byte offset for the next indexed element |
| idx_ready | output | 1 | Offset taken this cycle |
| busy | output | 1 | Operation in flight or finishing |
| out_valid | output | 1 | Address output is valid |
| out_addr | output | AW | Element byte address |
| out_elem | output | EW | Element number |
| out_en | output | 1 | Element enabled by mask |
| out_bank | output | BB | Bank selected by this address |
| conflict | output | 1 | Element held by a busy bank |
| done | output | 1 | Operation finished |

## Verification
Random operations cover all modes, element sizes, lengths, masks and strides. Each element is compared in address, enable, bank and issue cycle against a bench model that applies the bank busy window. Several directed cases are added. A zero stride and a stride of NBANK elements keep every access in one bank and show the stall spacing. An all-zero mask with the same strides shows that masked elements never stall. Length 0 and an over-long length check the count limits. Indexed runs with gaps in `idx_valid` separate handshake stalls from bank stalls. A stray `start` in mid-flight must leave the sequence unchanged.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW    = 32,
  parameter int MAXVL = 64,
  parameter int NBANK = 8,
  parameter int BUSY  = 2,
  localparam int CW = $clog2(MAXVL + 1),
  localparam int EW = $clog2(MAXVL),
  localparam int BB = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    stride,
  input  logic [CW-1:0]    vlen,
  input  logic [1:0]       esize,
  input  logic [MAXVL-1:0] mask,
  input  logic             idx_valid,
  input  logic [AW-1:0]    idx_off,
  output logic             idx_ready,
  output logic             busy,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic [EW-1:0]    out_elem,
  output logic             out_en,
  output logic [BB-1:0]    out_bank,
  output logic             conflict,
  output logic             done
);

  logic             run, lastq;
  logic [1:0]       md, es;
  logic [AW-1:0]    basq, cur, stp;
  logic [CW-1:0]    cnt, len;
  logic [MAXVL-1:0] msk;
  logic [BUSY-1:0]  hv;
  logic [BB-1:0]    hb [BUSY];

  logic             idx_m, en, want, hit, issue, last;
  logic [AW-1:0]    cand;
  logic [BB-1:0]    cbank;
  logic [BUSY-1:0]  match;
  logic [CW-1:0]    vclamp;

  assign idx_m  = (md == 2'd2);
  assign cand   = idx_m ? basq + idx_off : cur;
  assign cbank  = BB'(cand >> es);
  assign en     = msk[cnt[EW-1:0]];
  assign want   = !idx_m || idx_valid;

  for (genvar g = 0; g < BUSY; g++) begin : g_hist
    assign match[g] = hv[g] && (hb[g] == cbank);
  end

  assign hit       = en && (|match);
  assign issue     = run && want && !hit;
  assign last      = (cnt == len - 1'b1);
  assign idx_ready = run && idx_m && !hit;
  assign busy      = run || lastq;
  assign vclamp    = (vlen > CW'(MAXVL)) ? CW'(MAXVL) : vlen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; lastq <= 1'b0; md <= '0; es <= '0;
      basq <= '0; cur <= '0; stp <= '0; cnt <= '0; len <= '0; msk <= '0;
      hv <= '0;
      for (int i = 0; i < BUSY; i++) hb[i] <= '0;
      out_valid <= 1'b0; out_addr <= '0; out_elem <= '0; out_en <= 1'b0;
      out_bank <= '0; conflict <= 1'b0; done <= 1'b0;
    end else begin
      out_valid <= issue;
      conflict  <= run && want && hit;
      done      <= lastq;
      lastq     <= 1'b0;
      for (int i = BUSY - 1; i > 0; i--) begin
        hb[i] <= hb[i-1];
        hv[i] <= hv[i-1];
      end
      hb[0] <= cbank;
      hv[0] <= issue && en;
      if (issue) begin
        out_addr <= cand;
        out_elem <= cnt[EW-1:0];
        out_en   <= en;
        out_bank <= cbank;
        cnt      <= cnt + 1'b1;
        cur      <= cur + stp;
        if (last) begin
          run   <= 1'b0;
          lastq <= 1'b1;
        end
      end
      if (start && !busy) begin
        md   <= mode;
        es   <= esize;
        basq <= base;
        cur  <= base;
        stp  <= (mode == 2'd1) ? stride : (AW'(1) << esize);
        len  <= vclamp;
        msk  <= mask;
        cnt  <= '0;
        hv   <= '0;
        if (vclamp == '0) lastq <= 1'b1;
        else run <= 1'b1;
      end
    end
  end

  p_elem_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (!out_valid || out_elem == EW'($past(out_elem) + 1'b1)));

  p_elem_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CW'(out_elem) < len));

  p_idx_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_ready && idx_valid) |=> out_valid);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !out_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !run));

endmodule

// File: tb/tb_vec_addr_gen.sv
module tb_vec_addr_gen;
  localparam int AW = 32, MAXVL = 64, NBANK = 8, BUSY = 2;
  localparam int CW = $clog2(MAXVL + 1), EW = $clog2(MAXVL), BB = $clog2(NBANK);
  localparam time TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0, esize = '0;
  logic [AW-1:0] base = '0, stride = '0, idx_off = '0;
  logic [CW-1:0] vlen = '0;
  logic [MAXVL-1:0] mask = '0;
  logic idx_valid = 1'b0;
  logic idx_ready, busy, out_valid, out_en, conflict, done;
  logic [AW-1:0] out_addr;
  logic [EW-1:0] out_elem;
  logic [BB-1:0] out_bank;

  int checks = 0, fails = 0;
  int unsigned seed = 32'd1234;
  logic [AW-1:0] idx_tab [MAXVL];

  always #(TCLK/2) clk = ~clk;

  vec_addr_gen #(.AW(AW), .MAXVL(MAXVL), .NBANK(NBANK), .BUSY(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .esize(esize), .mask(mask),
    .idx_valid(idx_valid), .idx_off(idx_off), .idx_ready(idx_ready),
    .busy(busy), .out_valid(out_valid), .out_addr(out_addr),
    .out_elem(out_elem), .out_en(out_en), .out_bank(out_bank),
    .conflict(conflict), .done(done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] f_addr(input logic [1:0] md, input logic [AW-1:0] b,
      input logic [AW-1:0] s, input logic [1:0] e, input int i, input logic [AW-1:0] ix);
    if (md == 2'd1) return b + AW'(i) * s;
    if (md == 2'd2) return b + ix;
    return b + (AW'(i) << e);
  endfunction

  function automatic logic [BB-1:0] f_bank(input logic [AW-1:0] a, input logic [1:0] e);
    return BB'(a >> e);
  endfunction

  task automatic run_op(input logic [1:0] md, input logic [AW-1:0] b, input logic [AW-1:0] s,
      input int vl, input logic [1:0] e, input logic [MAXVL-1:0] m, input bit gap, input bit stray);
    int len, got, k, conf, stalls, dk, lastk, icnt, tprev;
    logic [AW-1:0] ea [MAXVL];
    int et [MAXVL];
    int lastb [NBANK];
    bit all_ok;
    string tag;
    len = (vl > MAXVL) ? MAXVL : vl;
    tag = (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : (md == 2'd3) ? "R12" : "R2";
    for (int i = 0; i < NBANK; i++) lastb[i] = -1000;
    tprev = 1; stalls = 0;
    for (int i = 0; i < len; i++) begin
      int t;
      idx_tab[i] = $urandom;
      ea[i] = f_addr(md, b, s, e, i, idx_tab[i]);
      t = tprev + 1;
      if (m[i]) begin
        if (lastb[f_bank(ea[i], e)] + BUSY + 1 > t) t = lastb[f_bank(ea[i], e)] + BUSY + 1;
        lastb[f_bank(ea[i], e)] = t;
      end
      stalls += t - tprev - 1;
      et[i] = t; tprev = t;
    end
    mode = md; base = b; stride = s; vlen = CW'(vl); esize = e; mask = m;
    start = 1'b1; icnt = 0;
    idx_off = idx_tab[0]; idx_valid = gap ? 1'($urandom % 2) : 1'b1;
    @(negedge clk);
    start = 1'b0; base = ~b;
    got = 0; conf = 0; dk = -1; lastk = 1; all_ok = 1'b1;
    for (k = 1; k < 3000; k++) begin
      if (out_valid) begin
        if (got < len) begin
          bit ok;
          ok = (out_addr == ea[got]) && (out_elem == EW'(got));
          chk(ok, {tag, " address/element"}, out_addr, ea[got]);
          chk(out_en == m[got], "R6 enable flag", out_en, m[got]);
          chk(out_bank == f_bank(ea[got], e), "R7 bank", out_bank, f_bank(ea[got], e));
          if (!gap) chk(k == et[got], "R1 issue cycle", k, et[got]);
          all_ok &= ok;
        end
        got++; lastk = k; icnt = int'(out_elem) + 1;
      end
      if (conflict) conf++;
      if (done) begin dk = k; break; end
      if (stray && k == 3) start = 1'b1;
      if (stray && k == 4) start = 1'b0;
      idx_off = idx_tab[icnt < MAXVL ? icnt : 0];
      idx_valid = gap ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
    end
    start = 1'b0; idx_valid = 1'b0;
    chk(got == len, "R5 element count", got, len);
    chk(dk == lastk + 1, "R9 done timing", dk, lastk + 1);
    if (!gap) chk(conf == stalls, "R8 conflict cycles", conf, stalls);
    if (stray) chk(all_ok && got == len, "R10 start ignored while busy", got, len);
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(!out_valid && !conflict && !done && !busy && !idx_ready, "R11 reset state",
        {out_valid, conflict, done, busy, idx_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(2'd0, 32'h1000, 0, 16, 2'd2, '1, 0, 0);
    run_op(2'd0, 32'h2000, 0, 10, 2'd3, '1, 0, 0);
    run_op(2'd3, 32'h3001, 0, 12, 2'd0, '1, 0, 0);
    run_op(2'd1, 32'h4000, 32'd0, 6, 2'd2, '1, 0, 0);
    run_op(2'd1, 32'h5000, 32'd32, 8, 2'd2, '1, 0, 0);
    run_op(2'd1, 32'h5000, 32'd32, 8, 2'd2, '0, 0, 0);
    run_op(2'd1, 32'h6000, -32'sd8, 9, 2'd3, 64'h5555, 0, 0);
    run_op(2'd0, 32'h7000, 0, 0, 2'd1, '1, 0, 0);
    run_op(2'd0, 32'h8000, 0, 100, 2'd0, '1, 0, 0);
    run_op(2'd2, 32'h9000, 0, 20, 2'd2, '1, 1, 0);
    run_op(2'd2, 32'hA000, 0, 20, 2'd1, {$urandom, $urandom}, 0, 0);
    run_op(2'd1, 32'hB000, 32'd12, 15, 2'd2, '1, 0, 1);
    for (int n = 0; n < 24; n++) begin
      logic [1:0] md;
      md = 2'($urandom % 4);
      run_op(md, $urandom, AW'($urandom % 80) - 32'd40, int'($urandom % 70),
             2'($urandom % 4), {$urandom, $urandom}, (md == 2'd2) && ($urandom % 2 == 0), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule